// File: doc/BRIEF.md
# Serial ADC Frame Reader

This block is the host side of a link to a two-input successive-approximation ADC. The converter sends each result as a 16-bit serial frame. The block drives the active-low chip select and the serial clock, and it reads the converter's data line. It always lowers chip select while the serial clock is low, so the converter uses the externally clocked timing. It then waits out the converter's wake-up time and clocks out one frame with the clock idling low. Each bit is captured on the rising clock edge. After the frame it returns chip select high and holds it there for a minimum time before the next frame.

Each frame holds three marker bits that must all be one, then a channel bit, then a 12-bit result sent MSB first. The block presents the result and the channel together with a one-cycle valid strobe. It flags frames whose marker bits are wrong. A frame is started either by a one-cycle request or, in continuous mode, back to back with no request. In continuous mode the converter is expected to alternate between its two inputs. The block raises a sticky warning if two consecutive frames carry the same channel.

All timing is counted in system clock cycles, derived from the system clock rate parameter. The defaults assume a 100 MHz system clock. With that clock the wake-up wait is 250 cycles and the minimum chip-select high time is 6 cycles. The serial half-period is held between 24 and 437 cycles. The upper bound is the tighter of two limits: the 100 kHz minimum serial rate, and the rule that 16 serial periods must fit inside the 140 µs hold window.

Top module: `adc_frame_reader`

## Requirements
- R1: While reset is held low, chip select is high, the serial clock is low, the valid strobe is low and both flags are low.
- R2: Chip select falls only in a cycle where the serial clock is low, and the serial clock is never high while chip select is high.
- R3: After chip select falls, at least 250 system cycles pass before the first rising serial clock edge.
- R4: Each frame has exactly 16 rising and 16 falling serial clock edges. Chip select rises in the same cycle as the 16th falling edge.
- R5: Every serial clock half-period equals the divider input clamped to the range 24..437. The value is taken when the frame starts, and divider changes made during a frame do not affect that frame.
- R6: Data is captured on rising serial clock edges. Frame bit 1 is the first bit captured, and bits 1-3 are marker bits. Bit 4 is the channel, and the result output carries bits 5 to 16 with bit 5 as its MSB.
- R7: The result, the channel and a single-cycle valid strobe are updated together. The valid strobe is high in the system cycle right after the cycle in which the 16th rising edge was captured. The result does not change when valid is low.
- R8: The framing-error output is updated together with valid. It is 1 if any of the three marker bits was 0, and 0 if all three were 1.
- R9: Between the end of one frame and the start of the next, chip select stays high for at least 6 system cycles, and this also applies after reset.
- R10: While the continuous input is high, frames start one after another with no start request.
- R11: In continuous mode, a frame whose channel equals the channel of the previous continuous frame sets the sequence-warning output together with valid. The warning then stays set until reset. Frames taken while continuous mode is off never set it.
- R12: A start request made while a frame is in progress is ignored and does not produce an extra frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle request for a single frame |
| cont_i | input | 1 | Continuous mode: start frames back to back |
| clk_div_i | input | 10 | Serial clock half-period in system cycles (clamped) |
| miso_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Active-low chip select to the converter |
| sclk_o | output | 1 | Serial clock to the converter, idles low |
| result_o | output | 12 | Last 12-bit conversion result |
| chan_o | output | 1 | Channel bit of the last frame |
| valid_o | output | 1 | One-cycle strobe: new result, channel and flags |
| frame_err_o | output | 1 | Marker bits of the last frame were not all ones |
| seq_warn_o | output | 1 | Sticky: a channel repeated in continuous mode |

## Verification
The valid strobe is due exactly one system cycle after the cycle in which the serial clock was first seen high for the 16th time. The bench watches for that rising edge on the falling system clock edge and checks valid at the next falling edge. The wake-up wait and the chip-select high time are both lower bounds, so they are checked as minimum cycle counts. Chip select rising is checked in the same sampled cycle as the 16th falling serial edge. Every half-period is measured between observed serial clock transitions and compared with the clamped divider latched when the frame started. A behavioural converter model shifts out queued frames. Expected results, channels and flags are popped from a scoreboard queue whenever valid is seen.

// File: rtl/adc_rd_pkg.sv
// Shared types and helpers for the serial ADC frame reader.
// Assumes: nothing beyond IEEE 1800-2017 constant functions.
package adc_rd_pkg;

    // Controller phases; chip select is high in RD_GAP and RD_IDLE.
    typedef enum logic [1:0] {
        RD_GAP   = 2'd0,
        RD_IDLE  = 2'd1,
        RD_WAKE  = 2'd2,
        RD_SHIFT = 2'd3
    } rd_state_t;

    // Ceiling division on 64-bit values for deriving cycle counts.
    function automatic longint ceil_div(input longint num, input longint den);
        return (num + den - 1) / den;
    endfunction

    // Smaller of two values.
    function automatic longint min2(input longint a, input longint b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/adc_rd_timer.sv
// Down-counting wait timer shared by the wake-up and chip-select gap waits.
// Assumes: load_i has priority; done_o is high whenever the count is zero.
module adc_rd_timer #(
    parameter int W       = 9,
    parameter int RST_VAL = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    output logic         done_o
);
    logic [W-1:0] cnt_q;

    // Load a new wait or count the current one down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= W'(RST_VAL);
        else if (load_i)
            cnt_q <= val_i;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign done_o = (cnt_q == '0);
endmodule

// File: rtl/adc_rd_sclk_gen.sv
// Serial clock generator: toggles the clock every half_i system cycles while
// run_i is high and counts falling edges so the frame can end on the last one.
// Assumes: half_i is at least 2 and stays constant while run_i is high.
module adc_rd_sclk_gen #(
    parameter int DIV_W      = 10,
    parameter int FRAME_BITS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [DIV_W-1:0] half_i,
    output logic             sclk_o,
    output logic             rise_o,
    output logic             last_fall_o
);
    localparam int FCW = $clog2(FRAME_BITS + 1);

    logic [DIV_W-1:0] hcnt_q;
    logic [FCW-1:0]   fcnt_q;
    logic             sclk_q;
    logic             tick;
    logic             fall;

    // A tick marks the system edge at which the serial clock changes level.
    always_comb begin
        tick        = run_i && (hcnt_q == half_i - 1'b1);
        rise_o      = tick && !sclk_q;
        fall        = tick && sclk_q;
        last_fall_o = fall && (fcnt_q == FCW'(FRAME_BITS - 1));
    end

    // Half-period counter, clock level and falling-edge count.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            hcnt_q <= '0;
            sclk_q <= 1'b0;
            fcnt_q <= '0;
        end else begin
            if (tick) begin
                hcnt_q <= '0;
                sclk_q <= ~sclk_q;
            end else begin
                hcnt_q <= hcnt_q + 1'b1;
            end
            if (fall)
                fcnt_q <= fcnt_q + 1'b1;
        end
    end

    assign sclk_o = sclk_q;
endmodule

// File: rtl/adc_rd_capture.sv
// Frame capture: shifts in one bit per rising serial edge, then publishes the
// result, channel, framing error and channel-sequence warning one cycle after
// the last bit.
// Assumes: clr_i pulses once at the start of every frame.
module adc_rd_capture #(
    parameter int DATA_W = 12,
    parameter int LEAD_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              rise_i,
    input  logic              miso_i,
    input  logic              cont_i,
    output logic [DATA_W-1:0] result_o,
    output logic              chan_o,
    output logic              valid_o,
    output logic              err_o,
    output logic              warn_o
);
    localparam int FB  = LEAD_W + 1 + DATA_W;
    localparam int BCW = $clog2(FB);

    logic [FB-1:0]  shreg_q;
    logic [BCW-1:0] bcnt_q;
    logic           done_q;
    logic           prev_ok_q;
    logic           prev_ch_q;
    logic           lead_ok;
    logic           new_ch;

    // Split the assembled frame into marker check and channel bit.
    always_comb begin
        lead_ok = &shreg_q[FB-1 -: LEAD_W];
        new_ch  = shreg_q[DATA_W];
    end

    // Shift register and bit counter; done_q flags the final bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q <= '0;
            bcnt_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (clr_i) begin
                bcnt_q <= '0;
            end else if (rise_i) begin
                shreg_q <= {shreg_q[FB-2:0], miso_i};
                if (bcnt_q == BCW'(FB - 1)) begin
                    bcnt_q <= '0;
                    done_q <= 1'b1;
                end else begin
                    bcnt_q <= bcnt_q + 1'b1;
                end
            end
        end
    end

    // Publish result, channel, error and strobe in one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_o <= '0;
            chan_o   <= 1'b0;
            err_o    <= 1'b0;
            valid_o  <= 1'b0;
        end else begin
            valid_o <= done_q;
            if (done_q) begin
                result_o <= shreg_q[DATA_W-1:0];
                chan_o   <= new_ch;
                err_o    <= !lead_ok;
            end
        end
    end

    // Track channel alternation across continuous frames; warning is sticky.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_ok_q <= 1'b0;
            prev_ch_q <= 1'b0;
            warn_o    <= 1'b0;
        end else if (!cont_i) begin
            prev_ok_q <= 1'b0;
        end else if (done_q) begin
            if (prev_ok_q && (new_ch == prev_ch_q))
                warn_o <= 1'b1;
            prev_ok_q <= 1'b1;
            prev_ch_q <= new_ch;
        end
    end
endmodule

// File: rtl/adc_frame_reader.sv
// Host-side reader for a two-input serial ADC using externally clocked frames.
// Sequences chip select, wake-up wait, 16 serial clocks (idle low, capture on
// rise) and the chip-select high gap; all timing in system clock cycles.
// Assumes: SYS_KHZ is the system clock rate; reset is synchronous, active low.
module adc_frame_reader
    import adc_rd_pkg::*;
#(
    parameter int SYS_KHZ      = 100000,
    parameter int DIV_W        = 10,
    parameter int DATA_W       = 12,
    parameter int LEAD_W       = 3,
    parameter int WAKE_NS      = 2500,
    parameter int CSH_NS       = 60,
    parameter int SCLK_MAX_KHZ = 2170,
    parameter int SCLK_MIN_KHZ = 100,
    parameter int HOLD_MAX_NS  = 140000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              cont_i,
    input  logic [DIV_W-1:0]  clk_div_i,
    input  logic              miso_i,
    output logic              cs_n_o,
    output logic              sclk_o,
    output logic [DATA_W-1:0] result_o,
    output logic              chan_o,
    output logic              valid_o,
    output logic              frame_err_o,
    output logic              seq_warn_o
);
    localparam int FRAME_BITS = LEAD_W + 1 + DATA_W;
    localparam int WAKE_CYC   = int'(ceil_div(longint'(SYS_KHZ) * WAKE_NS, 64'd1000000));
    localparam int CSH_CYC    = int'(ceil_div(longint'(SYS_KHZ) * CSH_NS, 64'd1000000));
    localparam int DIV_MIN    = int'(ceil_div(longint'(SYS_KHZ), 2 * longint'(SCLK_MAX_KHZ)));
    localparam int DIV_MAX    = int'(min2(longint'(SYS_KHZ) / (2 * SCLK_MIN_KHZ),
                                          longint'(SYS_KHZ) * HOLD_MAX_NS
                                          / (64'd1000000 * 2 * FRAME_BITS)));
    localparam int TW         = $clog2(((WAKE_CYC > CSH_CYC) ? WAKE_CYC : CSH_CYC) + 1);
    localparam logic [DIV_W-1:0] DIV_LO = DIV_W'(DIV_MIN);
    localparam logic [DIV_W-1:0] DIV_HI = DIV_W'(DIV_MAX);

    rd_state_t        state_q, state_n;
    logic             t_load;
    logic [TW-1:0]    t_val;
    logic             t_done;
    logic             begin_frame;
    logic [DIV_W-1:0] div_clamped;
    logic [DIV_W-1:0] div_q;
    logic             cs_q;
    logic             sclk_rise;
    logic             last_fall;

    // Clamp the requested half-period to the legal serial clock range.
    always_comb begin
        if (clk_div_i < DIV_LO)
            div_clamped = DIV_LO;
        else if (clk_div_i > DIV_HI)
            div_clamped = DIV_HI;
        else
            div_clamped = clk_div_i;
    end

    // Next-state logic: gap, idle, wake-up wait, shifting.
    always_comb begin
        state_n     = state_q;
        t_load      = 1'b0;
        t_val       = '0;
        begin_frame = 1'b0;
        case (state_q)
            RD_GAP:   if (t_done) state_n = RD_IDLE;
            RD_IDLE:  if (start_i || cont_i) begin
                          state_n     = RD_WAKE;
                          t_load      = 1'b1;
                          t_val       = TW'(WAKE_CYC);
                          begin_frame = 1'b1;
                      end
            RD_WAKE:  if (t_done) state_n = RD_SHIFT;
            RD_SHIFT: if (last_fall) begin
                          state_n = RD_GAP;
                          t_load  = 1'b1;
                          t_val   = TW'(CSH_CYC);
                      end
            default:  state_n = RD_GAP;
        endcase
    end

    // State, registered chip select and per-frame divider latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RD_GAP;
            cs_q    <= 1'b1;
            div_q   <= DIV_LO;
        end else begin
            state_q <= state_n;
            cs_q    <= (state_n == RD_GAP) || (state_n == RD_IDLE);
            if (begin_frame)
                div_q <= div_clamped;
        end
    end

    adc_rd_timer #(
        .W       (TW),
        .RST_VAL (CSH_CYC)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (t_load),
        .val_i  (t_val),
        .done_o (t_done)
    );

    adc_rd_sclk_gen #(
        .DIV_W      (DIV_W),
        .FRAME_BITS (FRAME_BITS)
    ) u_sclk (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_i       (state_q == RD_SHIFT),
        .half_i      (div_q),
        .sclk_o      (sclk_o),
        .rise_o      (sclk_rise),
        .last_fall_o (last_fall)
    );

    adc_rd_capture #(
        .DATA_W (DATA_W),
        .LEAD_W (LEAD_W)
    ) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (begin_frame),
        .rise_i   (sclk_rise),
        .miso_i   (miso_i),
        .cont_i   (cont_i),
        .result_o (result_o),
        .chan_o   (chan_o),
        .valid_o  (valid_o),
        .err_o    (frame_err_o),
        .warn_o   (seq_warn_o)
    );

    assign cs_n_o = cs_q;
endmodule

// File: rtl/adc_frame_reader_chk.sv
// Protocol checker for adc_frame_reader, attached with bind.
// Assumes: WAKE_CYC and CSH_CYC match the reader's derived cycle counts.
module adc_frame_reader_chk #(
    parameter int DATA_W   = 12,
    parameter int WAKE_CYC = 250,
    parameter int CSH_CYC  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n_o,
    input logic              sclk_o,
    input logic              valid_o,
    input logic [DATA_W-1:0] result_o,
    input logic              seq_warn_o
);
    logic [15:0] hi_cnt_q;
    logic [15:0] lo_cnt_q;
    logic        rise_seen_q;

    // Count cycles with chip select high and low, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cnt_q    <= '0;
            lo_cnt_q    <= '0;
            rise_seen_q <= 1'b0;
        end else if (cs_n_o) begin
            hi_cnt_q    <= (hi_cnt_q == 16'hFFFF) ? hi_cnt_q : hi_cnt_q + 1'b1;
            lo_cnt_q    <= '0;
            rise_seen_q <= 1'b0;
        end else begin
            hi_cnt_q    <= '0;
            lo_cnt_q    <= (lo_cnt_q == 16'hFFFF) ? lo_cnt_q : lo_cnt_q + 1'b1;
            if (sclk_o)
                rise_seen_q <= 1'b1;
        end
    end

    // R2
    cs_fall_sclk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n_o) |-> !sclk_o);
    // R2
    sclk_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> !sclk_o);
    // R3
    wake_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sclk_o) && !rise_seen_q) |-> (lo_cnt_q >= 16'(WAKE_CYC)));
    // R4
    cs_rise_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n_o) |-> $fell(sclk_o));
    // R9
    cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n_o) |-> (hi_cnt_q >= 16'(CSH_CYC)));
    // R7
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);
    // R7
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> $stable(result_o));
    // R11
    warn_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_warn_o |=> seq_warn_o);
endmodule

bind adc_frame_reader adc_frame_reader_chk #(
    .DATA_W   (DATA_W),
    .WAKE_CYC (WAKE_CYC),
    .CSH_CYC  (CSH_CYC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n_o     (cs_n_o),
    .sclk_o     (sclk_o),
    .valid_o    (valid_o),
    .result_o   (result_o),
    .seq_warn_o (seq_warn_o)
);

// File: tb/adc_frame_reader_bench.sv
// Scoreboard bench: driver tasks queue frames for a converter model and
// expected items for the monitor, which checks timing and popped results.
module adc_frame_reader_bench;
    localparam int CLK_PERIOD = 10;
    localparam int B_WAKE     = 250;
    localparam int B_CSH      = 6;
    localparam int B_DMIN     = 24;
    localparam int B_DMAX     = 437;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        cont = 1'b0;
    logic [9:0]  div = 10'd30;
    logic        miso = 1'b0;
    logic        cs_n;
    logic        sclk;
    logic [11:0] result;
    logic        chan;
    logic        valid;
    logic        ferr;
    logic        warn;

    adc_frame_reader u_adc_frame_reader (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .cont_i      (cont),
        .clk_div_i   (div),
        .miso_i      (miso),
        .cs_n_o      (cs_n),
        .sclk_o      (sclk),
        .result_o    (result),
        .chan_o      (chan),
        .valid_o     (valid),
        .frame_err_o (ferr),
        .seq_warn_o  (warn)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct packed {
        logic [11:0] res;
        logic        ch;
        logic        err;
        logic        wrn;
    } exp_t;

    exp_t        exp_q[$];
    logic [15:0] dev_q[$];
    int total = 0, bad = 0;
    int frames_started = 0, valid_cnt = 0;
    int exp_div = 30;
    bit model_warn = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Converter model and monitor, all on the falling system edge.
    logic        prev_cs = 1'b1, prev_sclk = 1'b0;
    logic [15:0] cur_frame = '0;
    int idx = 0, rise_cnt = 0, fall_cnt = 0, low_cyc = 0, half = 0;
    int hw_min = 0, hw_max = 0, gap = 0;
    bit vpend = 0;
    exp_t e;

    always @(negedge clk) begin
        if (rst_n) begin
            if (vpend) begin
                chk(valid == 1'b1, "R7", "valid one cycle after 16th rise", int'(valid), 1);
                vpend = 0;
            end
            if (!prev_cs) begin
                half++;
                if (rise_cnt == 0) low_cyc++;
                if (sclk && !prev_sclk) begin
                    rise_cnt++;
                    if (rise_cnt == 1)
                        chk(low_cyc >= B_WAKE, "R3", "cycles before first rise", low_cyc, B_WAKE);
                    else begin
                        if (half < hw_min) hw_min = half;
                        if (half > hw_max) hw_max = half;
                    end
                    half = 0;
                    if (rise_cnt == 16) vpend = 1;
                end
                if (!sclk && prev_sclk) begin
                    fall_cnt++;
                    if (half < hw_min) hw_min = half;
                    if (half > hw_max) hw_max = half;
                    half = 0;
                    idx++;
                    miso = (idx < 16) ? cur_frame[15-idx] : 1'b0;
                end
                if (cs_n) begin
                    chk(rise_cnt == 16, "R4", "rising edges per frame", rise_cnt, 16);
                    chk(fall_cnt == 16, "R4", "falling edges at cs rise", fall_cnt, 16);
                    chk(hw_min == exp_div && hw_max == exp_div, "R5", "half-period",
                        (hw_min != exp_div) ? hw_min : hw_max, exp_div);
                    gap = 0;
                end
            end
            if (prev_cs && !cs_n) begin
                chk(gap >= B_CSH, "R9", "cs high cycles", gap, B_CSH);
                frames_started++;
                rise_cnt = 0; fall_cnt = 0; low_cyc = 0; half = 0;
                hw_min = 1 << 30; hw_max = 0;
                cur_frame = (dev_q.size() != 0) ? dev_q.pop_front() : 16'h0000;
                idx = 0;
                miso = cur_frame[15];
            end
            if (cs_n) gap++;
            if (valid) begin
                valid_cnt++;
                if (exp_q.size() == 0) begin
                    chk(0, "R7", "unexpected valid", 1, 0);
                end else begin
                    e = exp_q.pop_front();
                    chk(result == e.res, "R6", "result", int'(result), int'(e.res));
                    chk(chan == e.ch, "R6", "channel", int'(chan), int'(e.ch));
                    chk(ferr == e.err, "R8", "framing error", int'(ferr), int'(e.err));
                    chk(warn == e.wrn, "R11", "sequence warning", int'(warn), int'(e.wrn));
                end
            end
        end
        prev_cs = cs_n;
        prev_sclk = sclk;
    end

    function automatic int clamp_div(input int d);
        return (d < B_DMIN) ? B_DMIN : (d > B_DMAX) ? B_DMAX : d;
    endfunction

    // Queue one frame for the model and its expected item for the monitor.
    task automatic push_frame(input logic [2:0] lead, input logic ch,
                              input logic [11:0] data);
        exp_t x;
        dev_q.push_back({lead, ch, data});
        x.res = data; x.ch = ch; x.err = (lead != 3'b111); x.wrn = model_warn;
        exp_q.push_back(x);
    endtask

    task automatic wait_done(input int target);
        while (valid_cnt < target) @(negedge clk);
        while (!cs_n) @(negedge clk);
        repeat (12) @(negedge clk);
    endtask

    task automatic single(input logic [2:0] lead, input logic ch,
                          input logic [11:0] data, input int d);
        int target;
        target = valid_cnt + 1;
        div = 10'(d);
        exp_div = clamp_div(d);
        push_frame(lead, ch, data);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(target);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        chk(0, "WD", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        int base_v, base_f;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(cs_n == 1'b1, "R1", "cs_n in reset", int'(cs_n), 1);
        chk(sclk == 1'b0, "R1", "sclk in reset", int'(sclk), 0);
        chk(valid == 1'b0 && ferr == 1'b0 && warn == 1'b0, "R1", "strobe/flags in reset",
            int'({valid, ferr, warn}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(cs_n == 1'b1, "R9", "cs_n held after reset", int'(cs_n), 1);
        repeat (10) @(negedge clk);

        single(3'b111, 1'b0, 12'hA5C, 30);       // R6 nominal
        single(3'b111, 1'b1, 12'hFFF, 0);        // R5 clamp to minimum
        single(3'b111, 1'b0, 12'h001, 1000);     // R5 clamp to maximum
        single(3'b101, 1'b1, 12'h5A5, 40);       // R8 bad marker bit
        chk(ferr == 1'b1, "R8", "error held after bad frame", int'(ferr), 1);

        // R5 mid-frame divider change and R12 start while busy
        div = 10'd30;
        exp_div = 30;
        push_frame(3'b111, 1'b0, 12'h800);
        base_v = valid_cnt + 1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (cs_n) @(negedge clk);
        repeat (5) @(negedge clk);
        div = 10'd50;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(base_v);
        chk(ferr == 1'b0, "R8", "error cleared by good frame", int'(ferr), 0);
        repeat (40) @(negedge clk);
        chk(frames_started == 5, "R12", "frames after busy start", frames_started, 5);
        chk(cs_n == 1'b1, "R12", "idle after busy start", int'(cs_n), 1);

        // R10/R11 continuous mode with a repeated channel
        div = 10'd24;
        exp_div = 24;
        base_v = valid_cnt;
        base_f = frames_started;
        model_warn = 0; push_frame(3'b111, 1'b0, 12'h123);
        model_warn = 0; push_frame(3'b111, 1'b1, 12'h456);
        model_warn = 1; push_frame(3'b111, 1'b1, 12'h789);
        model_warn = 1; push_frame(3'b111, 1'b0, 12'hABC);
        cont = 1'b1;
        while (valid_cnt < base_v + 4) @(negedge clk);
        cont = 1'b0;
        while (!cs_n) @(negedge clk);
        repeat (40) @(negedge clk);
        chk(frames_started == base_f + 4, "R10", "continuous frames", frames_started - base_f, 4);
        chk(warn == 1'b1, "R11", "warning sticky", int'(warn), 1);
        chk(exp_q.size() == 0, "R7", "scoreboard drained", exp_q.size(), 0);
        finish_run();
    end
endmodule